// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical address by looking up a descriptor in a small on-chip segment table. The upper bits of the address select a segment and the lower bits give an offset inside it. The selected descriptor supplies a base, a limit, a presence flag, separate read, write and fetch permissions, and a cacheable attribute. A legal access returns base plus offset with the cacheable attribute. An illegal access returns a 2-bit code that names the first rule it broke.

Two complete tables are held on chip, one per process context. A one-bit active-table register chooses which table serves requests, so a context switch takes a single register write. Software fills either table through a write port, whichever table is active at the time. Two tables may point a segment at the same physical base, which lets the two contexts share that segment. Every request produces exactly one registered result on the following cycle.

Top module: `seg_xlat`

## Requirements
- R1: The 32-bit virtual address is split into a segment number in bits 31:20 and an offset in bits 19:0. Each table holds entries for segments 0 to 15. Any segment number of 16 or more is treated as an entry whose presence flag is clear.
- R2: A request that does not fault returns rsp_paddr = base + offset, truncated to 32 bits, together with the entry's cacheable bit on rsp_cacheable.
- R3: A request to an entry whose presence flag is clear returns rsp_fault = 1.
- R4: A request to a present entry whose offset is greater than or equal to the entry limit returns rsp_fault = 2. The limit is 21 bits wide, so a limit of 0x100000 admits every offset.
- R5: The access kind on req_kind is 0 for read, 1 for write, 2 for fetch and 3 for reserved. A read needs the read permission, a write needs the write permission and a fetch needs the execute permission. A reserved access is never permitted. A present, in-limit request that lacks the needed permission returns rsp_fault = 3.
- R6: When several faults apply, code 1 wins over code 2, and code 2 wins over code 3. rsp_fault = 0 means the request did not fault.
- R7: Whenever rsp_fault is nonzero, rsp_paddr is 0 and rsp_cacheable is 0.
- R8: rsp_valid is high on the cycle after each cycle in which req_valid is high, and on no other cycle.
- R9: A write with tsel_we loads tsel_val into the active-table register. A request in the same cycle as that write still uses the previous table. A cfg_we write updates entry cfg_idx of table cfg_tbl, whatever table is active, and leaves the other table unchanged.
- R10: After reset, rsp_valid is 0, table 0 is active and every entry of both tables has its presence flag clear.
- R11: Entries in different tables that hold the same base give the same physical address for the same offset.
- R12: A request in the same cycle as a write to the entry it uses is translated with the entry's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_tbl | input | 1 | Table written by cfg_we |
| cfg_idx | input | 4 | Entry written by cfg_we |
| cfg_base | input | 32 | Physical base of the written entry |
| cfg_limit | input | 21 | Segment length of the written entry |
| cfg_present | input | 1 | Presence flag of the written entry |
| cfg_rd | input | 1 | Read permission of the written entry |
| cfg_wr | input | 1 | Write permission of the written entry |
| cfg_ex | input | 1 | Execute permission of the written entry |
| cfg_cache | input | 1 | Cacheable attribute of the written entry |
| tsel_we | input | 1 | Active-table register write strobe |
| tsel_val | input | 1 | New active-table value |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_cacheable | output | 1 | Cacheable attribute, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 over limit, 3 permission |

## Verification
Every table entry and the active-table bit are reachable only through translations, so a corrupted entry or a wrong table choice shows up in the very next result for that segment. It appears one cycle after the request as a wrong address, a wrong attribute or a wrong fault code. A broken priority between fault checks shows up only on requests that break more than one rule at once, so the stimulus builds such requests on purpose. Timing errors in the response register show up at once as a missing or an extra rsp_valid pulse.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int VA_W  = 32;
    localparam int SEG_W = 12;
    localparam int OFF_W = VA_W - SEG_W;
    localparam int PA_W  = 32;
    localparam int N_ENT = 16;
    localparam int N_TBL = 2;
    localparam int IDX_W = $clog2(N_ENT);
    localparam int TBL_W = (N_TBL > 1) ? $clog2(N_TBL) : 1;
    localparam int LIM_W = OFF_W + 1;

    typedef enum logic [1:0] {
        ACC_RD    = 2'd0,
        ACC_WR    = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Encoding is ordered by priority: a lower nonzero code wins.
    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_PERM   = 2'd3
    } flt_e;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
        logic             present;
        logic             rd;
        logic             wr;
        logic             ex;
        logic             cache;
    } desc_t;

    function automatic logic kind_allowed(desc_t d, acc_e k);
        case (k)
            ACC_RD:    return d.rd;
            ACC_WR:    return d.wr;
            ACC_FETCH: return d.ex;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [TBL_W-1:0] wtbl,
    input  logic [IDX_W-1:0] widx,
    input  desc_t            wdesc,
    input  logic [TBL_W-1:0] rtbl,
    input  logic [SEG_W-1:0] rseg,
    output desc_t            rdesc
);

    desc_t tbl_out [N_TBL];
    logic  in_range;

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        desc_t ent [N_ENT];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
            end else if (we && wtbl == TBL_W'(t)) begin
                ent[widx] <= wdesc;
            end
        end

        assign tbl_out[t] = ent[rseg[IDX_W-1:0]];

        AST_ENTRY_WRITTEN: assert property (@(posedge clk) disable iff (rst)
            we && wtbl == TBL_W'(t) |=> ent[$past(widx)] == $past(wdesc)); // R9
    end

    // Segment numbers beyond the table depth read as an absent entry.
    assign in_range = (rseg[SEG_W-1:IDX_W] == '0);

    always_comb begin
        rdesc = '0;
        if (in_range) rdesc = tbl_out[rtbl];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  desc_t            desc,
    input  logic [OFF_W-1:0] off,
    input  acc_e             kind,
    output flt_e             fault,
    output logic [PA_W-1:0]  paddr,
    output logic             cache
);

    logic over;

    always_comb begin
        over = ({1'b0, off} >= desc.limit);
        if (!desc.present)                  fault = FLT_ABSENT;
        else if (over)                      fault = FLT_LIMIT;
        else if (!kind_allowed(desc, kind)) fault = FLT_PERM;
        else                                fault = FLT_NONE;

        if (fault == FLT_NONE) begin
            paddr = desc.base + PA_W'(off);
            cache = desc.cache;
        end else begin
            paddr = '0;
            cache = 1'b0;
        end
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [TBL_W-1:0] cfg_tbl,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             cfg_present,
    input  logic             cfg_rd,
    input  logic             cfg_wr,
    input  logic             cfg_ex,
    input  logic             cfg_cache,
    input  logic             tsel_we,
    input  logic [TBL_W-1:0] tsel_val,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic [1:0]       rsp_fault
);

    logic [TBL_W-1:0] tsel;
    desc_t            wdesc;
    desc_t            rd_desc;
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    flt_e             nxt_fault;
    logic [PA_W-1:0]  nxt_paddr;
    logic             nxt_cache;

    assign seg = req_vaddr[VA_W-1:OFF_W];
    assign off = req_vaddr[OFF_W-1:0];

    always_comb begin
        wdesc         = '0;
        wdesc.base    = cfg_base;
        wdesc.limit   = cfg_limit;
        wdesc.present = cfg_present;
        wdesc.rd      = cfg_rd;
        wdesc.wr      = cfg_wr;
        wdesc.ex      = cfg_ex;
        wdesc.cache   = cfg_cache;
    end

    always_ff @(posedge clk) begin
        if (rst)          tsel <= '0;
        else if (tsel_we) tsel <= tsel_val;
    end

    seg_table u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wtbl  (cfg_tbl),
        .widx  (cfg_idx),
        .wdesc (wdesc),
        .rtbl  (tsel),
        .rseg  (seg),
        .rdesc (rd_desc)
    );

    seg_check u_check (
        .desc  (rd_desc),
        .off   (off),
        .kind  (acc_e'(req_kind)),
        .fault (nxt_fault),
        .paddr (nxt_paddr),
        .cache (nxt_cache)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
            rsp_fault     <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr     <= nxt_paddr;
                rsp_cacheable <= nxt_cache;
                rsp_fault     <= nxt_fault;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R8

    AST_FAULT_ZEROES_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0 && !rsp_cacheable); // R7

    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !rd_desc.present |=> rsp_fault == 2'd1); // R3

    AST_OVER_LIMIT_FAULTS: assert property (@(posedge clk) disable iff (rst)
        req_valid && rd_desc.present && ({1'b0, off} >= rd_desc.limit)
        |=> rsp_fault == 2'd2); // R4

    AST_TSEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tsel_we |=> $stable(tsel)); // R9

endmodule

// File: tb/seg_xlat_test.sv
`timescale 1ns/1ps
module seg_xlat_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_tbl = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [20:0] cfg_limit = '0;
    logic        cfg_present = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_ex = 1'b0, cfg_cache = 1'b0;
    logic        tsel_we = 1'b0;
    logic [0:0]  tsel_val = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable;
    logic [1:0]  rsp_fault;

    always #10 clk = ~clk;

    seg_xlat uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_present(cfg_present),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_ex(cfg_ex), .cfg_cache(cfg_cache),
        .tsel_we(tsel_we), .tsel_val(tsel_val),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_cacheable(rsp_cacheable), .rsp_fault(rsp_fault)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Bench-side model of both tables, filled from its own writes.
    logic [31:0] sh_base  [2][16];
    logic [20:0] sh_limit [2][16];
    logic        sh_p [2][16], sh_r [2][16], sh_w [2][16], sh_x [2][16], sh_c [2][16];
    int          sh_tsel = 0;

    bit          pend_wr = 0;
    int          pw_t, pw_i;
    logic [31:0] pw_base;
    logic [20:0] pw_lim;
    logic        pw_p, pw_r, pw_w, pw_x, pw_c;
    bit          pend_ts = 0;
    int          pts_val;

    logic [31:0] q_pa [$];
    logic        q_c  [$];
    logic [1:0]  q_f  [$];
    string       q_tag [$];

    task automatic fail(string tag, string what);
        errors++;
        $display("FAIL %s: %s", tag, what);
    endtask

    task automatic put_write(int t, int i, logic [31:0] b, logic [20:0] l,
                             logic p, logic r, logic w, logic x, logic c);
        cfg_we = 1'b1; cfg_tbl = t[0:0]; cfg_idx = i[3:0];
        cfg_base = b; cfg_limit = l; cfg_present = p;
        cfg_rd = r; cfg_wr = w; cfg_ex = x; cfg_cache = c;
        pend_wr = 1; pw_t = t; pw_i = i; pw_base = b; pw_lim = l;
        pw_p = p; pw_r = r; pw_w = w; pw_x = x; pw_c = c;
    endtask

    task automatic put_tsel(int v);
        tsel_we = 1'b1; tsel_val = v[0:0];
        pend_ts = 1; pts_val = v;
    endtask

    // Driver: computes the expected result from the model and queues it.
    task automatic put_req(logic [31:0] va, int kind, string tag);
        int          seg, t;
        logic [20:0] off;
        logic        p, ok;
        logic [1:0]  f;
        logic [31:0] pa;
        logic        c;
        seg = int'(va[31:20]);
        off = {1'b0, va[19:0]};
        t   = sh_tsel;
        p   = (seg < 16) ? sh_p[t][seg] : 1'b0;
        f = 2'd0; pa = 32'd0; c = 1'b0;
        if (!p) f = 2'd1;
        else if (off >= sh_limit[t][seg]) f = 2'd2;
        else begin
            case (kind)
                0: ok = sh_r[t][seg];
                1: ok = sh_w[t][seg];
                2: ok = sh_x[t][seg];
                default: ok = 1'b0;
            endcase
            if (!ok) f = 2'd3;
            else begin
                pa = sh_base[t][seg] + {12'd0, va[19:0]};
                c  = sh_c[t][seg];
            end
        end
        req_valid = 1'b1; req_vaddr = va; req_kind = kind[1:0];
        q_pa.push_back(pa); q_c.push_back(c); q_f.push_back(f); q_tag.push_back(tag);
    endtask

    task automatic step();
        @(posedge clk);
        if (pend_wr) begin
            sh_base[pw_t][pw_i] = pw_base; sh_limit[pw_t][pw_i] = pw_lim;
            sh_p[pw_t][pw_i] = pw_p; sh_r[pw_t][pw_i] = pw_r; sh_w[pw_t][pw_i] = pw_w;
            sh_x[pw_t][pw_i] = pw_x; sh_c[pw_t][pw_i] = pw_c;
            pend_wr = 0;
        end
        if (pend_ts) begin sh_tsel = pts_val; pend_ts = 0; end
        #2;
        cfg_we = 1'b0; tsel_we = 1'b0; req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic req(logic [31:0] va, int kind, string tag);
        put_req(va, kind, tag);
        step();
    endtask

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            vectors++;
            if (q_f.size() == 0) begin
                fail("R8", $sformatf("response with no request pending, fault=%0d paddr=%h exp none",
                                     rsp_fault, rsp_paddr));
            end else begin
                logic [31:0] epa; logic ec; logic [1:0] ef; string et;
                epa = q_pa.pop_front(); ec = q_c.pop_front();
                ef = q_f.pop_front(); et = q_tag.pop_front();
                if (rsp_paddr !== epa || rsp_cacheable !== ec || rsp_fault !== ef)
                    fail(et, $sformatf("paddr=%h c=%0b fault=%0d exp paddr=%h c=%0b fault=%0d",
                                       rsp_paddr, rsp_cacheable, rsp_fault, epa, ec, ef));
            end
        end
    end

    task automatic check_idle(string tag);
        vectors++;
        if (rsp_valid !== 1'b0) fail(tag, $sformatf("rsp_valid=%b exp 0", rsp_valid));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run hung, got no end exp end");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 16; i++) begin
                sh_base[t][i] = '0; sh_limit[t][i] = '0;
                sh_p[t][i] = 0; sh_r[t][i] = 0; sh_w[t][i] = 0; sh_x[t][i] = 0; sh_c[t][i] = 0;
            end
        repeat (3) @(negedge clk);
        check_idle("R10");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R10");

        // R10: every entry absent after reset, table 0 active
        req(32'h0000_0010, 0, "R10");
        req(32'h00F0_0000, 1, "R10");

        // table 0 contents
        put_write(0, 0,  32'h0010_0000, 21'h0A000,  1, 1, 1, 0, 1); step();
        put_write(0, 1,  32'h0030_0000, 21'h100000, 1, 1, 0, 1, 0); step();
        put_write(0, 2,  32'h0070_0000, 21'h01000,  1, 0, 0, 0, 1); step();
        put_write(0, 3,  32'h0080_0000, 21'h00000,  0, 1, 1, 1, 1); step();
        put_write(0, 15, 32'hFFFF_F000, 21'h100000, 1, 1, 1, 1, 1); step();
        // table 1 contents
        put_write(1, 0,  32'h0050_0000, 21'h08000,  1, 1, 1, 1, 0); step();
        put_write(1, 1,  32'h0030_0000, 21'h100000, 1, 1, 0, 1, 0); step();
        @(negedge clk);
        check_idle("R8");

        // back-to-back requests on table 0
        put_req(32'h0000_1234, 0, "R2");  step();
        put_req(32'h0000_9FFF, 1, "R4");  step();
        put_req(32'h0000_A000, 0, "R4");  step();
        put_req(32'h0000_0010, 2, "R5");  step();
        req(32'h0010_0040, 1, "R5");
        req(32'h001F_FFFF, 2, "R4");
        req(32'h0020_0000, 0, "R5");
        req(32'h0020_1000, 0, "R6");
        req(32'h0030_0500, 0, "R3");
        req(32'h0030_0000, 3, "R6");
        req(32'h0100_0000, 0, "R1");
        req(32'hFFF0_0004, 0, "R1");
        req(32'h00F0_2000, 3, "R5");
        req(32'h00F0_2000, 0, "R2");
        @(negedge clk);
        check_idle("R8");

        // R9: switch in same cycle as a request -> old table used
        put_tsel(1);
        put_req(32'h0000_0100, 2, "R9");
        step();
        req(32'h0000_0100, 2, "R9");
        req(32'h0000_7FFF, 0, "R9");
        req(32'h0020_0000, 0, "R9");
        req(32'h0010_0ABC, 2, "R11");

        // R12: write and request to the same entry in one cycle
        put_write(1, 0, 32'h0060_0000, 21'h08000, 1, 1, 1, 1, 1);
        put_req(32'h0000_0020, 0, "R12");
        step();
        req(32'h0000_0020, 0, "R12");

        // R9: write to inactive table 0 is invisible until it is selected
        put_write(0, 2, 32'h0090_0000, 21'h02000, 1, 1, 1, 0, 0); step();
        req(32'h0020_0010, 0, "R9");
        put_tsel(0); step();
        req(32'h0020_0010, 0, "R9");
        req(32'h0010_0ABC, 2, "R11");
        req(32'h0000_1234, 0, "R2");

        @(negedge clk);
        @(negedge clk);
        check_idle("R8");
        vectors++;
        if (q_f.size() != 0) fail("R8", $sformatf("%0d responses missing exp 0", q_f.size()));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule